// File: doc/BRIEF.md
# PWM-PAM Combined Symbol Encoder

This block turns a stream of 4-bit nibbles into three-slot line symbols. Each symbol combines two codes. A pulse-width code carries the top bit of the nibble and gives the line one rising edge per symbol, so a receiver can recover its clock from the line. An amplitude code carries the other three bits, one bit in each slot. The polarity of a slot comes from the PWM waveform. Its magnitude (one unit or three units) comes from that slot's data bit.

The block runs on a slot-rate clock, so one symbol lasts three cycles. In every slot it drives a 2-bit level index for a downstream analog driver, the raw PWM waveform bit, and a strobe that marks the first slot of each symbol. Nibbles arrive on a valid/ready handshake. The encoder accepts a nibble only in the last slot of the symbol before the one that carries it. When no nibble is offered, it sends an all-zero symbol so the clock edge is never lost.

Top module: `pwam_sym_enc`

## Requirements
- R1: A symbol lasts exactly three clock cycles. `sym_start_o` is high in the first of them and low in the other two. The first symbol after reset is released begins on the first clock edge after release.
- R2: `pwm_o` is high in slot 1 of every symbol and low in slot 3. Its only rising edge is therefore at the start of each symbol.
- R3: Nibble bit 3 sets the pulse width. With bit 3 = 0, `pwm_o` is high in slot 1 only. With bit 3 = 1, it is high in slots 1 and 2.
- R4: The magnitude of each slot comes from one nibble bit: slot 1 uses bit 2, slot 2 uses bit 1, and slot 3 uses bit 0.
- R5: The level index is encoded as 2'b00 = -3, 2'b01 = -1, 2'b10 = +1 and 2'b11 = +3. When PWM is high, the level is +1 for a data bit of 0 and +3 for a data bit of 1. When PWM is low, the level is -1 for 0 and -3 for 1.
- R6: `nib_ready_o` is high only in the capture slot. The capture slot is slot 3 of a running symbol, or the idle cycle after reset. On the edge that ends the capture slot, `nib_i` is taken when `nib_valid_i` is high.
- R7: Changes on `nib_i` or `nib_valid_i` outside the capture slot have no effect on the symbol being sent.
- R8: If `nib_valid_i` is low in the capture slot, the next symbol is built from nibble 4'b0000.
- R9: While reset is held, the outputs are level 2'b01, `pwm_o` low, `sym_start_o` low and `nib_ready_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nib_i | input | 4 | Data nibble |
| nib_valid_i | input | 1 | Nibble valid |
| nib_ready_o | output | 1 | High in the capture slot |
| pwm_o | output | 1 | PWM waveform bit of the current slot |
| level_o | output | 2 | Level index of the current slot |
| sym_start_o | output | 1 | High in slot 1 of each symbol |

## Verification
The assertions assume that reset is applied at time zero and that the clock runs without gaps. The strobe and PWM relations then follow from the counter alone, whatever data arrives. They place no limit on when `nib_i` or `nib_valid_i` may change. For that reason the stimulus deliberately drives a complemented nibble, with valid high, throughout slots 1 and 2 of every symbol, to show that only capture-slot values matter. It sweeps all sixteen nibbles and also leaves valid low in some capture slots.

// File: rtl/pwam_pkg.sv
package pwam_pkg;
  localparam int unsigned SLOTS = 3;
  localparam int unsigned NIB_W = SLOTS + 1;
  localparam int unsigned CNT_W = $clog2(SLOTS);

  typedef enum logic [1:0] {
    LVL_M3 = 2'b00,
    LVL_M1 = 2'b01,
    LVL_P1 = 2'b10,
    LVL_P3 = 2'b11
  } level_e;

  // sign from pwm, magnitude from data bit
  function automatic level_e map_level(input logic pwm, input logic bit_v);
    return level_e'(pwm ? {1'b1, bit_v} : {1'b0, ~bit_v});
  endfunction
endpackage

// File: rtl/pwam_slot_ctr.sv
module pwam_slot_ctr
  import pwam_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] slot_o,
  output logic             live_o,
  output logic             cap_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

  logic [CNT_W-1:0] slot_q;
  logic             live_q;

  assign cap_o  = (slot_q == LAST);
  assign slot_o = slot_q;
  assign live_o = live_q;

  // reset parks on the capture slot so the first symbol starts one edge later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= LAST;
      live_q <= 1'b0;
    end else if (cap_o) begin
      slot_q <= '0;
      live_q <= 1'b1;
    end else begin
      slot_q <= slot_q + 1'b1;
    end
  end

  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(slot_q) < SLOTS); // R1
  AST_LIVE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |=> live_q); // R1
endmodule

// File: rtl/pwam_nib_hold.sv
module pwam_nib_hold
  import pwam_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             valid_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic [NIB_W-1:0] nib_o
);
  logic [NIB_W-1:0] nib_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    nib_q <= '0;
    else if (cap_i) nib_q <= valid_i ? nib_i : '0;
  end

  assign nib_o = nib_q;

  AST_NIB_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(nib_q)); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !valid_i) |=> (nib_q == '0)); // R8
endmodule

// File: rtl/pwam_level_map.sv
module pwam_level_map
  import pwam_pkg::*;
(
  input  logic [CNT_W-1:0] slot_i,
  input  logic             live_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic             pwm_o,
  output level_e           level_o
);
  localparam int unsigned SEL_N = 2 ** CNT_W;

  logic [SEL_N-1:0] sel;

  // slot g carries nibble bit SLOTS-1-g; unused codes read zero
  for (genvar g = 0; g < SEL_N; g++) begin : g_sel
    if (g < SLOTS) begin : g_used
      assign sel[g] = nib_i[SLOTS-1-g];
    end else begin : g_pad
      assign sel[g] = 1'b0;
    end
  end

  logic bit_v;
  assign bit_v = sel[slot_i];

  // high for (top bit + 1) slots from symbol start
  assign pwm_o   = live_i && (slot_i <= CNT_W'(nib_i[NIB_W-1]));
  assign level_o = live_i ? map_level(pwm_o, bit_v) : LVL_M1;
endmodule

// File: rtl/pwam_sym_enc.sv
module pwam_sym_enc
  import pwam_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NIB_W-1:0] nib_i,
  input  logic             nib_valid_i,
  output logic             nib_ready_o,
  output logic             pwm_o,
  output logic [1:0]       level_o,
  output logic             sym_start_o
);
  logic [CNT_W-1:0] slot;
  logic             live;
  logic             cap;
  logic [NIB_W-1:0] nib_h;
  level_e           lvl;

  pwam_slot_ctr u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_o (slot),
    .live_o (live),
    .cap_o  (cap)
  );

  pwam_nib_hold u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .valid_i (nib_valid_i),
    .nib_i   (nib_i),
    .nib_o   (nib_h)
  );

  pwam_level_map u_map (
    .slot_i  (slot),
    .live_i  (live),
    .nib_i   (nib_h),
    .pwm_o   (pwm_o),
    .level_o (lvl)
  );

  assign level_o     = lvl;
  assign nib_ready_o = cap;
  assign sym_start_o = live && (slot == '0);

  AST_START_AFTER_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_start_o |-> $past(nib_ready_o)); // R6
  AST_START_POSITIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_start_o |-> (pwm_o && level_o[1])); // R2
  AST_SLOT3_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_start_o |-> ##2 (!pwm_o && nib_ready_o && !level_o[1])); // R2
  AST_NO_DOUBLE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_start_o |=> !sym_start_o); // R1
  AST_RISE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_o) |-> sym_start_o); // R2
  AST_READY_THEN_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_ready_o |=> sym_start_o); // R1
endmodule

// File: tb/sim_pwam_sym_enc.sv
module sim_pwam_sym_enc;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] nib_i = 4'h0;
  logic       nib_valid_i = 1'b0;
  logic       nib_ready_o;
  logic       pwm_o;
  logic [1:0] level_o;
  logic       sym_start_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  pwam_sym_enc u0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .nib_i       (nib_i),
    .nib_valid_i (nib_valid_i),
    .nib_ready_o (nib_ready_o),
    .pwm_o       (pwm_o),
    .level_o     (level_o),
    .sym_start_o (sym_start_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // signed level -> index: (v+3)/2
  function automatic int exp_lvl(input bit pwm, input bit b);
    int v;
    v = pwm ? (b ? 3 : 1) : (b ? -3 : -1);
    return (v + 3) / 2;
  endfunction

  task automatic check_idle(input string tag);
    chk({tag, " R9 level"}, level_o, 1);
    chk({tag, " R9 pwm"}, pwm_o, 0);
    chk({tag, " R9 start"}, sym_start_o, 0);
    chk({tag, " R9 ready"}, nib_ready_o, 1);
  endtask

  task automatic send(input bit v, input logic [3:0] n);
    logic [3:0] e;
    bit p;
    e = v ? n : 4'h0;
    chk("R6 ready in capture slot", nib_ready_o, 1);
    nib_i = n;
    nib_valid_i = v;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk_i);
      nib_i = ~n;        // R7 garbage outside capture slot
      nib_valid_i = 1'b1;
      p = (s == 0) || (s == 1 && e[3]);
      chk($sformatf("R1 start slot%0d nib=%h", s + 1, e), sym_start_o, (s == 0) ? 1 : 0);
      chk($sformatf("R3 R2 pwm slot%0d nib=%h", s + 1, e), pwm_o, p);
      chk($sformatf("R4 R5 R7 R8 level slot%0d nib=%h", s + 1, e), level_o,
          exp_lvl(p, e[2 - s]));
      chk($sformatf("R6 ready slot%0d", s + 1), nib_ready_o, (s == 2) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    check_idle("reset");
    rst_ni = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    // no edge has captured yet; still idle after one cycle? first edge started symbol
    chk("R1 first symbol on first edge", sym_start_o, 1);
    // resync: let this zero symbol finish
    @(negedge clk_i);
    @(negedge clk_i);
    for (int k = 0; k < 16; k++) send(1'b1, 4'(k));
    send(1'b0, 4'hF);
    send(1'b0, 4'hA);
    send(1'b1, 4'h9);
    send(1'b0, 4'h6);
    rst_ni = 1'b0;
    #1;
    check_idle("midrun");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule